// File: doc/BRIEF.md
# CPU Exception Acceptance Arbiter

This block picks, once per instruction boundary, the single exception that a CPU core must service next. Four sources compete: reset, trace, interrupt and trap instruction. A reset comes from the rising edge of an asynchronous reset pin or from a watchdog overflow pulse. Trace and interrupt are level requests that are looked at only when the core marks the end of an instruction or of exception handling. A trap strobe is latched, so it can wait for a later boundary.

The core marks a boundary with a one-cycle strobe. Alongside the strobe it raises two flags: one for an instruction that has just modified a control register, one for a return-from-exception. The arbiter answers in the same cycle with a one-hot grant, a two-bit vector code and a valid bit. A reset grant does not wait for a boundary. Three context rules narrow the fixed order. Trace counts only in one selected interrupt-control mode. Trace is dropped after a return-from-exception. Interrupts are held off at a boundary after a control-register write, and at the first boundary after reset handling.

Top module: `exc_arbiter`

## Requirements
- R1: `in_reset_o` is 1 while `rst_n` is low. Otherwise it follows the inverse of the reset pin after a SYNC_STAGES-cycle synchronizer. While `in_reset_o` is 1 no grant is issued, and a pending trap or watchdog pulse is discarded.
- R2: A rising edge of the synchronized reset pin gives exactly one reset grant (`grant_o[0]`, `vec_o`=0) one cycle later, with no boundary needed.
- R3: A watchdog pulse while not in reset gives a reset grant in the next cycle. The reset grant also discards any latched trap.
- R4: At a boundary the fixed order is reset, trace, interrupt, trap. Requests that lose stay pending: trap stays latched, and levels are sampled again at the next boundary.
- R5: Trace (`grant_o[1]`, `vec_o`=1) is granted only when `trace_en_i`=1 and `intm_i` equals TRACE_MODE (default 2). In any other mode the trace bit has no effect.
- R6: No trace grant at a boundary whose `bnd_rte_i` is 1.
- R7: No interrupt grant (`grant_o[2]`, `vec_o`=2) at a boundary whose `bnd_ctl_i` is 1.
- R8: The first boundary after a reset grant grants no interrupt. Later boundaries grant interrupts normally.
- R9: A trap strobe (`grant_o[3]`, `vec_o`=3) is accepted in any cycle outside reset, at a boundary or not. It is held until it is granted at a boundary.
- R10: Every grant lasts one cycle, has at most one bit set, and comes with `vec_valid_o`=1 and `vec_o` equal to the granted bit index. Only reset is granted outside a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| res_pin_i | input | 1 | Asynchronous reset pin, low holds the core in reset |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| trace_en_i | input | 1 | Trace enable bit |
| intm_i | input | 2 | Interrupt control mode |
| irq_i | input | 1 | Interrupt request level |
| trap_i | input | 1 | Trap instruction strobe |
| bnd_i | input | 1 | Boundary strobe: instruction or exception handling ends |
| bnd_ctl_i | input | 1 | Completed instruction modified a control register |
| bnd_rte_i | input | 1 | Completed instruction was a return-from-exception |
| grant_o | output | 4 | One-hot grant: bit0 reset, bit1 trace, bit2 interrupt, bit3 trap |
| vec_o | output | 2 | Vector code of the grant |
| vec_valid_o | output | 1 | Grant valid |
| in_reset_o | output | 1 | Core held in reset state |

## Verification
The bench builds the block with SYNC_STAGES=2 and TRACE_MODE=2. At those values the synchronizer delay is short enough that one run can drop and raise the pin twice. Collisions such as a watchdog pulse meeting a boundary, or a trap strobe landing while the pin is still being synchronized low, can then be set up exactly. With TRACE_MODE=2 the bench can sweep all four mode values on one trace bit and show that only one of them opens trace.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  localparam int EXC_KINDS = 4;
  localparam int VEC_W     = $clog2(EXC_KINDS);

  typedef enum logic [1:0] {
    VEC_RESET = 2'd0,
    VEC_TRACE = 2'd1,
    VEC_IRQ   = 2'd2,
    VEC_TRAP  = 2'd3
  } exc_vec_e;

  // Bit index of a one-hot grant, 0 when none is set.
  function automatic logic [VEC_W-1:0] onehot_to_code(input logic [EXC_KINDS-1:0] oh);
    logic [VEC_W-1:0] c;
    c = '0;
    for (int i = 0; i < EXC_KINDS; i++)
      if (oh[i]) c = c | VEC_W'(i);
    return c;
  endfunction

  function automatic logic trace_allowed(input logic tbit, input logic [1:0] mode,
                                         input logic [1:0] want, input logic rte);
    return tbit && (mode == want) && !rte;
  endfunction

  function automatic logic irq_allowed(input logic irq, input logic ctl, input logic after_rst);
    return irq && !ctl && !after_rst;
  endfunction
endpackage

// File: rtl/exc_res_sync.sv
module exc_res_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic sync_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin_i;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin_i};
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_o;

  assign rise_o = sync_o & ~last_q;
endmodule

// File: rtl/exc_pend_state.sv
module exc_pend_state
  import exc_arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_reset_i,
  input  logic                 rise_i,
  input  logic                 wdt_i,
  input  logic                 bnd_i,
  input  logic                 trap_i,
  input  logic [EXC_KINDS-1:0] grant_i,
  output logic                 rst_pend_o,
  output logic                 after_rst_o,
  output logic                 trap_pend_o
);
  logic took_rst, took_trap;
  assign took_rst  = grant_i[int'(VEC_RESET)];
  assign took_trap = grant_i[int'(VEC_TRAP)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend_o  <= 1'b0;
      after_rst_o <= 1'b0;
      trap_pend_o <= 1'b0;
    end else if (in_reset_i) begin
      rst_pend_o  <= 1'b0;
      after_rst_o <= 1'b0;
      trap_pend_o <= 1'b0;
    end else begin
      rst_pend_o <= (rst_pend_o & ~took_rst) | rise_i | wdt_i;
      if (took_rst)   after_rst_o <= 1'b1;
      else if (bnd_i) after_rst_o <= 1'b0;
      if (took_rst || took_trap) trap_pend_o <= 1'b0;
      else                       trap_pend_o <= trap_pend_o | trap_i;
    end
  end
endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] taken;
  assign taken[0] = 1'b0;

  generate
    for (genvar g = 0; g < N; g++) begin : g_slot
      assign gnt_o[g]     = req_i[g] & ~taken[g];
      assign taken[g + 1] = taken[g] | req_i[g];
    end
  endgenerate
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_arb_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [1:0] TRACE_MODE  = 2'd2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 res_pin_i,
  input  logic                 wdt_ovf_i,
  input  logic                 trace_en_i,
  input  logic [1:0]           intm_i,
  input  logic                 irq_i,
  input  logic                 trap_i,
  input  logic                 bnd_i,
  input  logic                 bnd_ctl_i,
  input  logic                 bnd_rte_i,
  output logic [EXC_KINDS-1:0] grant_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 vec_valid_o,
  output logic                 in_reset_o
);
  logic res_sync, res_rise;
  logic rst_pend, after_rst, trap_pend;
  logic bnd_live, trace_req, irq_req, trap_req;
  logic [EXC_KINDS-1:0] req;

  exc_res_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (res_pin_i),
    .sync_o (res_sync),
    .rise_o (res_rise)
  );

  assign in_reset_o = ~res_sync;

  exc_pend_state u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_reset_i  (in_reset_o),
    .rise_i      (res_rise),
    .wdt_i       (wdt_ovf_i),
    .bnd_i       (bnd_i),
    .trap_i      (trap_i),
    .grant_i     (grant_o),
    .rst_pend_o  (rst_pend),
    .after_rst_o (after_rst),
    .trap_pend_o (trap_pend)
  );

  assign bnd_live  = bnd_i & ~in_reset_o;
  assign trace_req = bnd_live & trace_allowed(trace_en_i, intm_i, TRACE_MODE, bnd_rte_i);
  assign irq_req   = bnd_live & irq_allowed(irq_i, bnd_ctl_i, after_rst);
  assign trap_req  = bnd_live & (trap_pend | trap_i);

  always_comb begin
    req                  = '0;
    req[int'(VEC_RESET)] = rst_pend & ~in_reset_o;
    req[int'(VEC_TRACE)] = trace_req;
    req[int'(VEC_IRQ)]   = irq_req;
    req[int'(VEC_TRAP)]  = trap_req;
  end

  exc_prio_sel #(.N(EXC_KINDS)) u_prio (
    .req_i (req),
    .gnt_o (grant_o)
  );

  assign vec_o       = onehot_to_code(grant_o);
  assign vec_valid_o = |grant_o;
endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk #(
  parameter logic [1:0] TRACE_MODE = 2'd2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wdt_ovf_i,
  input logic [1:0] intm_i,
  input logic       bnd_i,
  input logic       bnd_ctl_i,
  input logic       bnd_rte_i,
  input logic [3:0] grant_o,
  input logic [1:0] vec_o,
  input logic       vec_valid_o,
  input logic       in_reset_o,
  input logic       after_rst
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R10
  AST_VEC_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> grant_o[vec_o]); // R10
  AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_o[3:1]) |-> bnd_i); // R10
  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset_o |-> !vec_valid_o); // R1
  AST_RESET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o[0] && !wdt_ovf_i) |=> !grant_o[0]); // R2
  AST_WDT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_ovf_i && !in_reset_o) |=> (grant_o[0] || in_reset_o)); // R3
  AST_TRACE_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[1] |-> (intm_i == TRACE_MODE)); // R5
  AST_NO_TRACE_AFTER_RTE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[1] |-> !bnd_rte_i); // R6
  AST_IRQ_CTL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[2] |-> !bnd_ctl_i); // R7
  AST_IRQ_POST_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[2] |-> !after_rst); // R8
endmodule

bind exc_arbiter exc_arbiter_chk #(.TRACE_MODE(TRACE_MODE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wdt_ovf_i   (wdt_ovf_i),
  .intm_i      (intm_i),
  .bnd_i       (bnd_i),
  .bnd_ctl_i   (bnd_ctl_i),
  .bnd_rte_i   (bnd_rte_i),
  .grant_o     (grant_o),
  .vec_o       (vec_o),
  .vec_valid_o (vec_valid_o),
  .in_reset_o  (in_reset_o),
  .after_rst   (after_rst)
);

// File: tb/exc_arbiter_tb.sv
`timescale 1ns/1ps
module exc_arbiter_tb;
  localparam int         SYNC = 2;
  localparam logic [1:0] TMODE = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pin = 1'b0, wdt = 1'b0, tb_en = 1'b0, irq = 1'b0;
  logic trap = 1'b0, bnd = 1'b0, ctl = 1'b0, rte = 1'b0;
  logic [1:0] intm = 2'd0;
  logic [3:0] grant;
  logic [1:0] vec;
  logic       vvalid, in_rst;

  always #2 clk = ~clk;

  exc_arbiter #(.SYNC_STAGES(SYNC), .TRACE_MODE(TMODE)) u_dut (
    .clk(clk), .rst_n(rst_n), .res_pin_i(pin), .wdt_ovf_i(wdt), .trace_en_i(tb_en),
    .intm_i(intm), .irq_i(irq), .trap_i(trap), .bnd_i(bnd), .bnd_ctl_i(ctl),
    .bnd_rte_i(rte), .grant_o(grant), .vec_o(vec), .vec_valid_o(vvalid),
    .in_reset_o(in_rst)
  );

  // Reference model state
  bit    hist[$];
  bit    m_rpend, m_after, m_trap;
  int    e_g;
  int    n_cmp = 0, n_bad = 0, cycles = 0;
  bit    done = 0;
  string cur_req = "R1";

  initial for (int i = 0; i <= SYNC; i++) hist.push_back(1'b0);

  always @(negedge clk) begin
    bit   exp_in;
    int   exp_vec;
    logic [3:0] exp_g;
    exp_in = !rst_n || !hist[SYNC-1];
    e_g = 0;
    if (!exp_in) begin
      if (m_rpend) e_g = 1;
      else if (bnd) begin
        if (tb_en && intm == TMODE && !rte) e_g = 2;
        else if (irq && !ctl && !m_after)  e_g = 4;
        else if (m_trap || trap)           e_g = 8;
      end
    end
    exp_g   = 4'(e_g);
    exp_vec = (e_g == 8) ? 3 : (e_g == 4) ? 2 : (e_g == 2) ? 1 : 0;
    n_cmp++;
    if (grant !== exp_g || vvalid !== (e_g != 0) || in_rst !== exp_in ||
        (e_g != 0 && vec !== 2'(exp_vec))) begin
      n_bad++;
      $display("FAIL %s t=%0t grant=%b vec=%0d valid=%b in_reset=%b expected grant=%b vec=%0d valid=%b in_reset=%b",
               cur_req, $time, grant, vec, vvalid, in_rst, exp_g, exp_vec, e_g != 0, exp_in);
    end
  end

  always @(posedge clk) begin
    bit rise_m, inr_m;
    if (!rst_n) begin
      for (int i = 0; i <= SYNC; i++) hist[i] = 1'b0;
      m_rpend = 0; m_after = 0; m_trap = 0;
    end else begin
      rise_m = hist[SYNC-1] && !hist[SYNC];
      inr_m  = !hist[SYNC-1];
      if (inr_m) begin
        m_rpend = 0; m_after = 0; m_trap = 0;
      end else begin
        m_rpend = (m_rpend && e_g != 1) || rise_m || wdt;
        if (e_g == 1) m_after = 1;
        else if (bnd) m_after = 0;
        if (e_g == 1 || e_g == 8) m_trap = 0;
        else m_trap = m_trap || trap;
      end
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      n_bad++;
      $display("FAIL R10 watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cur_req = "R1"; cyc(3);
    rst_n = 1'b1; cyc(4);
    cur_req = "R2"; pin = 1'b1; cyc(6);
    cur_req = "R8"; irq = 1; bnd = 1; cyc(1);
    bnd = 0; cyc(1); bnd = 1; cyc(1);
    bnd = 0; irq = 0; cyc(2);
    cur_req = "R5"; tb_en = 1; bnd = 1;
    for (int m = 0; m < 4; m++) begin intm = 2'(m); cyc(1); end
    bnd = 0; cyc(1);
    cur_req = "R6"; intm = 2'd2; rte = 1; bnd = 1; cyc(1);
    irq = 1; cyc(1); rte = 0; cyc(1);
    bnd = 0; irq = 0; tb_en = 0; cyc(1);
    cur_req = "R7"; irq = 1; ctl = 1; bnd = 1; cyc(1);
    ctl = 0; cyc(1); bnd = 0; irq = 0; cyc(1);
    cur_req = "R9"; trap = 1; cyc(1); trap = 0; cyc(5);
    bnd = 1; cyc(2); trap = 1; cyc(1); trap = 0; bnd = 0; cyc(1);
    cur_req = "R4"; trap = 1; cyc(1); trap = 0;
    tb_en = 1; irq = 1; bnd = 1; cyc(1);
    tb_en = 0; cyc(1); irq = 0; cyc(1); cyc(1); bnd = 0; cyc(1);
    cur_req = "R3"; trap = 1; cyc(1); trap = 0;
    wdt = 1; cyc(1); wdt = 0; cyc(1);
    bnd = 1; irq = 1; cyc(1); irq = 0; cyc(1); bnd = 0; cyc(1);
    cur_req = "R10"; wdt = 1; cyc(1); wdt = 0;
    irq = 1; bnd = 1; cyc(3); irq = 0; bnd = 0; cyc(2);
    cur_req = "R1"; pin = 0; cyc(1); trap = 1; wdt = 1; cyc(2);
    trap = 0; wdt = 0; cyc(4);
    bnd = 1; irq = 1; tb_en = 1; cyc(2); bnd = 0;
    cur_req = "R2"; pin = 1; cyc(6);
    bnd = 1; cyc(3); bnd = 0; irq = 0; tb_en = 0; cyc(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule